// File: doc/BRIEF.md
# Pipelined Tower-Field AES Byte Substitution

This block performs the forward AES byte substitution on one byte per clock cycle using gate logic alone, with no lookup table. Each incoming byte is carried by a linear change of basis from GF(2^8) (reduced by x^8+x^4+x^3+x+1) into a three-level tower field. In the tower field it is inverted with small 4-bit and 2-bit field operations. The result is carried back to the standard basis, and the AES affine map, which includes the constant 0x63, is applied to it.

The tower is built in three levels:

- GF(2^2) over GF(2) uses x^2+x+1.
- GF(2^4) over GF(2^2) uses x^2+x+phi, with phi = 2'b10.
- GF(2^8) over GF(2^4) uses x^2+x+lambda, with lambda = 4'b1100.

A tower byte is written as a high nibble h and a low nibble l. Its inverse has the high nibble h·e and the low nibble (h^l)·e, where e is the inverse of lambda·h^2 ^ l·(h^l).

The datapath is divided by four register stages:

1. Basis change in, and computation of the nibble to be inverted.
2. 4-bit inversion.
3. The two 4-bit products.
4. Basis change out and affine map.

A valid flag moves through the same four stages, so a result appears exactly four cycles after its byte is accepted, and a new byte can be accepted on every cycle. The block is meant to be replicated per state byte inside a cipher round datapath.

Top module: `aes_tower_sbox_pipe`

## Requirements
- R1: For every input value 0x00..0xFF, `out_byte` equals the AES forward substitution of that value.
- R2: A byte presented with `in_valid`=1 at a rising edge appears on `out_byte` with `out_valid`=1 after exactly four rising edges. There is no other latency.
- R3: Bytes presented with `in_valid`=1 on consecutive cycles produce results on consecutive cycles, in the same order.
- R4: While `rst` is high at a rising edge, every valid stage is cleared. `out_valid` is 0 on the first cycle after reset, and stays 0 until four edges after the first accepted byte.
- R5: Input 0x00 is inverted to zero inside the datapath, so its output is 0x63.
- R6: A cycle with `in_valid`=0 produces `out_valid`=0 four cycles later and does not disturb results before or after it.
- R7: Fixed vectors: 0x01 gives 0x7C, 0x53 gives 0xED, and 0xFF gives 0x16.
- R8: No output equals the input byte it was computed from (the substitution has no fixed point).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the valid stages |
| in_valid | input | 1 | Input byte is present this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | `out_byte` holds a result |
| out_byte | output | 8 | Substituted byte |

## Verification
The hardest case to reach is keeping results paired with their inputs when valid and idle cycles are mixed irregularly, and when special values such as 0x00 sit directly next to bubbles or right after reset. The stimulus first makes an exhaustive back-to-back sweep of all 256 values. It then places the directed bytes between idle cycles and reasserts reset while data is in flight. Finally it runs a seeded random stream in which both the byte and the valid flag are random.

// File: rtl/sbox_gf_pkg.sv
package sbox_gf_pkg;

    localparam int BYTE_W   = 8;
    localparam int NIB_W    = BYTE_W / 2;
    localparam int PAIR_W   = NIB_W / 2;
    localparam int STAGES   = 4;
    localparam logic [BYTE_W-1:0] AFF_C = 8'h63;

    // GF(2^2) product, modulus x^2+x+1
    function automatic logic [1:0] gf4_mul(input logic [1:0] q, input logic [1:0] w);
        logic [1:0] k;
        k[1] = (q[1] & w[1]) ^ (q[0] & w[1]) ^ (q[1] & w[0]);
        k[0] = (q[1] & w[1]) ^ (q[0] & w[0]);
        return k;
    endfunction

    // GF(2^2) product by phi = 2'b10
    function automatic logic [1:0] gf4_phi(input logic [1:0] q);
        return {q[1] ^ q[0], q[1]};
    endfunction

    // GF(2^4) square
    function automatic logic [3:0] gf16_sq(input logic [3:0] q);
        return {q[3], q[3] ^ q[2], q[2] ^ q[1], q[3] ^ q[1] ^ q[0]};
    endfunction

    // GF(2^4) product by lambda = 4'b1100
    function automatic logic [3:0] gf16_lam(input logic [3:0] q);
        return {q[2] ^ q[0], q[3] ^ q[2] ^ q[1] ^ q[0], q[3], q[2]};
    endfunction

    // GF(2^4) product, modulus x^2+x+phi over GF(2^2)
    function automatic logic [3:0] gf16_mul(input logic [3:0] q, input logic [3:0] w);
        logic [1:0] hh, hi, lo;
        hh = gf4_mul(q[3:2], w[3:2]);
        hi = hh ^ gf4_mul(q[3:2], w[1:0]) ^ gf4_mul(q[1:0], w[3:2]);
        lo = gf4_phi(hh) ^ gf4_mul(q[1:0], w[1:0]);
        return {hi, lo};
    endfunction

    // GF(2^4) inverse as per-bit sum of products, zero maps to zero
    function automatic logic [3:0] gf16_inv(input logic [3:0] q);
        logic [3:0] k;
        k[3] = q[3] ^ (q[3] & q[2] & q[1]) ^ (q[3] & q[0]) ^ q[2];
        k[2] = (q[3] & q[2] & q[1]) ^ (q[3] & q[2] & q[0]) ^ (q[3] & q[0])
             ^ q[2] ^ (q[2] & q[1]);
        k[1] = q[3] ^ (q[3] & q[2] & q[1]) ^ (q[3] & q[1] & q[0]) ^ q[2]
             ^ (q[2] & q[0]) ^ q[1];
        k[0] = (q[3] & q[2] & q[1]) ^ (q[3] & q[2] & q[0]) ^ (q[3] & q[1])
             ^ (q[3] & q[1] & q[0]) ^ (q[3] & q[0]) ^ q[2] ^ (q[2] & q[1])
             ^ (q[2] & q[1] & q[0]) ^ q[1] ^ q[0];
        return k;
    endfunction

    // Standard basis to tower basis
    function automatic logic [7:0] iso_in(input logic [7:0] q);
        logic [7:0] a;
        a[7] = q[7] ^ q[5];
        a[6] = q[7] ^ q[6] ^ q[4] ^ q[3] ^ q[2] ^ q[1];
        a[5] = q[7] ^ q[5] ^ q[3] ^ q[2];
        a[4] = q[7] ^ q[5] ^ q[3] ^ q[2] ^ q[1];
        a[3] = q[7] ^ q[6] ^ q[2] ^ q[1];
        a[2] = q[7] ^ q[4] ^ q[3] ^ q[2] ^ q[1];
        a[1] = q[6] ^ q[4] ^ q[1];
        a[0] = q[6] ^ q[1] ^ q[0];
        return a;
    endfunction

    // Tower basis back to standard basis
    function automatic logic [7:0] iso_out(input logic [7:0] q);
        logic [7:0] b;
        b[7] = q[7] ^ q[6] ^ q[5] ^ q[1];
        b[6] = q[6] ^ q[2];
        b[5] = q[6] ^ q[5] ^ q[1];
        b[4] = q[6] ^ q[5] ^ q[4] ^ q[2] ^ q[1];
        b[3] = q[5] ^ q[4] ^ q[3] ^ q[2] ^ q[1];
        b[2] = q[7] ^ q[4] ^ q[3] ^ q[2] ^ q[1];
        b[1] = q[5] ^ q[4];
        b[0] = q[6] ^ q[5] ^ q[4] ^ q[2] ^ q[0];
        return b;
    endfunction

endpackage

// File: rtl/sbox_front.sv
module sbox_front
    import sbox_gf_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output logic [NIB_W-1:0]  hi_o,
    output logic [NIB_W-1:0]  lo_o,
    output logic [NIB_W-1:0]  den_o
);
    logic [BYTE_W-1:0] tw;

    always_comb begin
        tw    = iso_in(byte_i);
        hi_o  = tw[BYTE_W-1:NIB_W];
        lo_o  = tw[NIB_W-1:0];
        den_o = gf16_lam(gf16_sq(hi_o)) ^ gf16_mul(lo_o, hi_o ^ lo_o);
    end
endmodule

// File: rtl/sbox_nib_inv.sv
module sbox_nib_inv
    import sbox_gf_pkg::*;
(
    input  logic [NIB_W-1:0] den_i,
    output logic [NIB_W-1:0] inv_o
);
    always_comb inv_o = gf16_inv(den_i);
endmodule

// File: rtl/sbox_back.sv
module sbox_back
    import sbox_gf_pkg::*;
(
    input  logic [BYTE_W-1:0] tw_i,
    output logic [BYTE_W-1:0] sub_o
);
    logic [BYTE_W-1:0] std;

    always_comb begin
        std = iso_out(tw_i);
        for (int i = 0; i < BYTE_W; i++) begin
            sub_o[i] = std[i] ^ std[(i + 4) % BYTE_W] ^ std[(i + 5) % BYTE_W]
                     ^ std[(i + 6) % BYTE_W] ^ std[(i + 7) % BYTE_W] ^ AFF_C[i];
        end
    end
endmodule

// File: rtl/aes_tower_sbox_pipe.sv
module aes_tower_sbox_pipe
    import sbox_gf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    logic [STAGES-1:0] vld_q;

    logic [NIB_W-1:0] f_hi, f_lo, f_den;
    logic [NIB_W-1:0] s1_hi, s1_lo, s1_den;
    logic [NIB_W-1:0] n_inv;
    logic [NIB_W-1:0] s2_hi, s2_lo, s2_inv;
    logic [BYTE_W-1:0] s3_tw;
    logic [BYTE_W-1:0] b_sub;
    logic [BYTE_W-1:0] s4_out;

    sbox_front u_front (.byte_i(in_byte), .hi_o(f_hi), .lo_o(f_lo), .den_o(f_den));
    sbox_nib_inv u_inv (.den_i(s1_den), .inv_o(n_inv));
    sbox_back u_back (.tw_i(s3_tw), .sub_o(b_sub));

    // valid shift chain, one bit per register stage
    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[STAGES-2:0], in_valid};
    end

    // data stages, no reset needed
    always_ff @(posedge clk) begin
        s1_hi  <= f_hi;
        s1_lo  <= f_lo;
        s1_den <= f_den;
        s2_hi  <= s1_hi;
        s2_lo  <= s1_lo;
        s2_inv <= n_inv;
        s3_tw  <= {gf16_mul(s2_hi, s2_inv), gf16_mul(s2_hi ^ s2_lo, s2_inv)};
        s4_out <= b_sub;
    end

    assign out_valid = vld_q[STAGES-1];
    assign out_byte  = s4_out;
endmodule

// File: rtl/sbox_pipe_chk.sv
module sbox_pipe_chk
    import sbox_gf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [BYTE_W-1:0] in_byte,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_byte
);
    logic [2:0] since_rst;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)                since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end
    assign warm = (since_rst >= 3'd4);

    // R4
    rst_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    // R2
    latency_four_chk: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_valid == $past(in_valid, 4)));

    // R5
    zero_gives_63_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_valid, 4) && $past(in_byte, 4) == 8'h00) |-> out_byte == 8'h63);

    // R7
    one_gives_7c_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_valid, 4) && $past(in_byte, 4) == 8'h01) |-> out_byte == 8'h7C);

    // R8
    no_fixed_point_chk: assert property (@(posedge clk) disable iff (rst)
        (warm && out_valid) |-> out_byte != $past(in_byte, 4));
endmodule

bind aes_tower_sbox_pipe sbox_pipe_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte)
);

// File: tb/sim_aes_tower_sbox_pipe.sv
module sim_aes_tower_sbox_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // expected-latency model: four slots
    logic       ev [4];
    logic [7:0] eb [4];
    logic [7:0] ein [4];
    string      etag [4];
    string      cur_tag = "R1";

    aes_tower_sbox_pipe u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
                            .out_valid(out_valid), .out_byte(out_byte));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = xt(x);
        end
        return p;
    endfunction

    function automatic logic [7:0] ref_sub(input logic [7:0] a);
        logic [7:0] p = 8'h01;
        logic [7:0] s;
        for (int i = 0; i < 254; i++) p = gmul(p, a);
        if (a == 8'h00) p = 8'h00;
        for (int i = 0; i < 8; i++)
            s[i] = p[i] ^ p[(i+4)%8] ^ p[(i+5)%8] ^ p[(i+6)%8] ^ p[(i+7)%8] ^ ((8'h63 >> i) & 1);
        return s;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            for (int i = 0; i < 4; i++) ev[i] <= 1'b0;
        end else begin
            ev[0] <= in_valid; eb[0] <= ref_sub(in_byte); ein[0] <= in_byte; etag[0] <= cur_tag;
            for (int i = 1; i < 4; i++) begin
                ev[i] <= ev[i-1]; eb[i] <= eb[i-1]; ein[i] <= ein[i-1]; etag[i] <= etag[i-1];
            end
        end
    end

    // compare away from the rising edge
    always @(negedge clk) begin
        if (!rst && !done && ev[3] !== 1'bx) begin
            n_cmp++;
            if (out_valid !== ev[3]) begin
                n_bad++;
                $display("FAIL %s/R2/R6 out_valid actual=%b expected=%b", etag[3], out_valid, ev[3]);
            end else if (ev[3]) begin
                n_cmp++;
                if (out_byte !== eb[3]) begin
                    n_bad++;
                    $display("FAIL %s in=%h actual=%h expected=%h", etag[3], ein[3], out_byte, eb[3]);
                end
                n_cmp++;
                if (out_byte === ein[3]) begin
                    n_bad++;
                    $display("FAIL R8 in=%h actual=%h expected=not %h", ein[3], out_byte, ein[3]);
                end
            end
        end
    end

    task automatic put(input logic v, input logic [7:0] b, input string tag);
        @(negedge clk);
        in_valid = v; in_byte = b; cur_tag = tag;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin ev[i] = 1'b0; eb[i] = 8'h00; ein[i] = 8'h00; etag[i] = "R4"; end
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4: first cycle after reset shows no valid
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R4 out_valid after reset actual=%b expected=0", out_valid);
        end
        in_valid = 1'b0;
        // R1/R3: exhaustive back-to-back sweep
        for (int v = 0; v < 256; v++) put(1'b1, v[7:0], "R1/R3");
        put(1'b0, 8'h00, "R6");
        // R5/R7 directed, separated by bubbles
        put(1'b1, 8'h00, "R5");
        put(1'b0, 8'hAA, "R6");
        put(1'b1, 8'h01, "R7");
        put(1'b1, 8'h53, "R7");
        put(1'b0, 8'h53, "R6");
        put(1'b0, 8'h11, "R6");
        put(1'b1, 8'hFF, "R7");
        put(1'b1, 8'h00, "R5");
        put(1'b0, 8'h00, "R6");
        // R4: reset with data in flight
        put(1'b1, 8'h3C, "R4");
        @(negedge clk); rst = 1'b1; in_valid = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        repeat (4) begin
            n_cmp++;
            if (out_valid !== 1'b0) begin
                n_bad++;
                $display("FAIL R4 out_valid during flush actual=%b expected=0", out_valid);
            end
            @(negedge clk);
        end
        // R6/R1 seeded random stream with random gaps
        void'($urandom(32'h5B0C));
        for (int k = 0; k < 2000; k++)
            put(($urandom % 4) != 0, 8'($urandom), "R1/R6");
        put(1'b0, 8'h00, "R6");
        repeat (8) @(negedge clk);
        finish_run();
    end

    initial begin
        wait (cycles >= WATCHDOG);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            finish_run();
        end
    end
endmodule